// File: doc/BRIEF.md
# Vector Pattern Sequencer

This block walks a vector memory and presents one vector address per clock to a downstream pin formatter. Vectors run in ascending order unless the opcode stored with the current vector changes the flow. Flow can branch unconditionally, branch on the delayed fail status from the formatter, repeat a section a counted number of times (nested), or enter and leave subroutines. Other opcodes raise a flag the host can read, stall until the host raises its own flag, and drive an external trigger line as a level or as a one-cycle pulse.

A pattern is loaded through a write port while the sequencer is idle. A start request begins a burst at vector 0. A HALT vector ends one pass of the pattern. After two drain cycles, in which the last fail results arrive, the selected stop policy either ends the burst or restarts the pattern at vector 0. The policies are: repeat until a pass fails, repeat until a pass is clean, or repeat until aborted. Stack misuse ends the burst with an error code.

Top module: `pat_seq`

## Requirements
- R1: A memory word is {opcode[3:0], operand[AW-1:0]}. Opcode 0 (and 13 to 15) moves to the next address. After reset the block is idle: busy, vec_valid, trig_out, seq_flag and err_code are all 0.
- R2: A start request while idle makes vector 0 valid on vec_addr in the cycle after the request. It clears err_code, seq_flag, trig_out, burst_fail and both stacks.
- R3: Opcode 1 moves to the operand address. Opcode 2 moves to the operand address only when fail_in is high in the cycle its vector is presented; fail_in carries the result of the vector two cycles earlier. Otherwise opcode 2 falls through.
- R4: Opcode 3 (loop begin, operand n) and opcode 4 (loop end) run the body between them max(n,1) times. Loops nest up to 4 deep.
- R5: Opcode 5 pushes the next address and moves to the operand address. Opcode 6 resumes at the pushed address. Calls nest up to 8 deep.
- R6: A call with 8 entries pushed ends the burst with err_code 1. A return with none pushed gives code 2. A loop begin with 4 entries active gives code 3. A loop end with none active gives code 4. The faulting vector is still presented, and busy is low in the next cycle.
- R7: Opcode 10 drives trig_out high from the next vector until an opcode 12 vector has run. Opcode 11 drives it high for exactly the one following cycle.
- R8: Opcode 8 sets seq_flag from the next cycle until the next start. Opcode 9 keeps presenting the same vector while host_flag is low, then moves on.
- R9: Opcode 7 ends a pass. Two cycles with vec_valid low follow. Any fail_in seen during the pass or the drain sets burst_fail.
- R10: At the end of a pass, mode 1 stops if a fail was seen and otherwise restarts. Mode 2 stops if no fail was seen and otherwise restarts. Modes 0 and 3 always restart. A restart presents vector 0 again.
- R11: abort ends a running or draining burst; busy is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write enable for vector memory |
| ld_addr | input | AW | Vector memory write address |
| ld_data | input | AW+4 | Word written: opcode and operand |
| start | input | 1 | Begin a burst (ignored while busy) |
| abort | input | 1 | Stop the burst |
| mode | input | 2 | Stop policy: 0/3 until abort, 1 until fail, 2 until pass |
| fail_in | input | 1 | Delayed fail status from the formatter |
| host_flag | input | 1 | Host handshake flag awaited by opcode 9 |
| vec_addr | output | AW | Address of the vector in execution |
| vec_valid | output | 1 | vec_addr holds an executing vector |
| busy | output | 1 | Burst running or draining |
| seq_flag | output | 1 | Flag raised by opcode 8 |
| trig_out | output | 1 | External trigger line |
| burst_fail | output | 1 | A fail was seen in the last finished pass |
| err_code | output | 3 | Reason the last burst ended on an error, 0 if none |

## Verification
The hardest case to reach is the interaction between the delayed fail status and flow decisions. This covers a conditional branch that must see a fail aligned to its own vector, and a stop decision that must wait for the results of the last two vectors. The bench drives fail_in from a responder that watches vec_addr and raises it exactly while a chosen address is presented. Toggling that responder between passes makes the until-fail and until-pass policies first restart and then stop. The stack error paths are reached by self-recursive calls and over-deep loop nesting.

// File: rtl/pat_seq.sv
module pat_seq #(
  parameter int AW       = 8,
  parameter int CS_DEPTH = 8,
  parameter int LS_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW+3:0] ld_data,
  input  logic          start,
  input  logic          abort,
  input  logic [1:0]    mode,
  input  logic          fail_in,
  input  logic          host_flag,
  output logic [AW-1:0] vec_addr,
  output logic          vec_valid,
  output logic          busy,
  output logic          seq_flag,
  output logic          trig_out,
  output logic          burst_fail,
  output logic [2:0]    err_code
);
  localparam int CIW = $clog2(CS_DEPTH);
  localparam int LIW = $clog2(LS_DEPTH);
  localparam int CSW = CIW + 1;
  localparam int LSW = LIW + 1;

  localparam logic [3:0] OP_JMP = 4'd1, OP_JFL = 4'd2, OP_LPB = 4'd3, OP_LPE = 4'd4,
                         OP_CALL = 4'd5, OP_RET = 4'd6, OP_HALT = 4'd7, OP_FLAG = 4'd8,
                         OP_WAIT = 4'd9, OP_TSET = 4'd10, OP_TPLS = 4'd11, OP_TCLR = 4'd12;
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_DRAIN = 2'd2;

  logic [AW+3:0] mem [2**AW];
  logic [AW+3:0] ins;
  logic [AW-1:0] cur, nxt;
  logic [1:0]    st;
  logic [AW-1:0] cstk [CS_DEPTH];
  logic [AW-1:0] lstart [LS_DEPTH];
  logic [AW-1:0] lcnt [LS_DEPTH];
  logic [CSW-1:0] csp;
  logic [LSW-1:0] lsp;
  logic [2:0]    err;
  logic          dcnt, fseen, trig_lvl, trig_pls;

  wire [3:0]     op   = ins[AW+3:AW];
  wire [AW-1:0]  opd  = ins[AW-1:0];
  wire [CIW-1:0] ctop = CIW'(csp - 1'b1);
  wire [LIW-1:0] ltop = LIW'(lsp - 1'b1);
  wire           go   = (st == S_RUN) && !abort && (err == 3'd0);
  wire           fails = fseen | fail_in;
  wire           stop_now = (mode == 2'd1 && fails) || (mode == 2'd2 && !fails);

  assign vec_addr  = cur;
  assign vec_valid = (st == S_RUN);
  assign busy      = (st != S_IDLE);
  assign trig_out  = trig_lvl | trig_pls;

  always_comb begin
    nxt = cur + AW'(1);
    err = 3'd0;
    if (st != S_RUN || abort) nxt = '0;
    else begin
      case (op)
        OP_JMP:  nxt = opd;
        OP_JFL:  if (fail_in) nxt = opd;
        OP_LPB:  if (lsp == LSW'(LS_DEPTH)) err = 3'd3;
        OP_LPE:  if (lsp == '0) err = 3'd4;
                 else if (lcnt[ltop] > AW'(1)) nxt = lstart[ltop];
        OP_CALL: if (csp == CSW'(CS_DEPTH)) err = 3'd1; else nxt = opd;
        OP_RET:  if (csp == '0) err = 3'd2; else nxt = cstk[ctop];
        OP_WAIT: if (!host_flag) nxt = cur;
        default: ;
      endcase
      if (err != 3'd0 || op == OP_HALT) nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    ins <= mem[nxt];
    if (go && op == OP_CALL) cstk[csp[CIW-1:0]] <= cur + AW'(1);
    if (go && op == OP_LPB) begin
      lstart[lsp[LIW-1:0]] <= cur + AW'(1);
      lcnt[lsp[LIW-1:0]]   <= opd;
    end
    if (go && op == OP_LPE && lcnt[ltop] > AW'(1)) lcnt[ltop] <= lcnt[ltop] - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; csp <= '0; lsp <= '0; dcnt <= 1'b0; fseen <= 1'b0;
      burst_fail <= 1'b0; err_code <= 3'd0; seq_flag <= 1'b0; trig_lvl <= 1'b0; trig_pls <= 1'b0;
    end else begin
      cur      <= nxt;
      trig_pls <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; csp <= '0; lsp <= '0; fseen <= 1'b0; err_code <= 3'd0;
          seq_flag <= 1'b0; trig_lvl <= 1'b0; burst_fail <= 1'b0;
        end
        S_RUN: begin
          fseen <= fails;
          if (abort) st <= S_IDLE;
          else if (err != 3'd0) begin
            err_code <= err;
            st <= S_IDLE;
          end else begin
            case (op)
              OP_LPB:  lsp <= lsp + 1'b1;
              OP_LPE:  if (lcnt[ltop] <= AW'(1)) lsp <= lsp - 1'b1;
              OP_CALL: csp <= csp + 1'b1;
              OP_RET:  csp <= csp - 1'b1;
              OP_FLAG: seq_flag <= 1'b1;
              OP_TSET: trig_lvl <= 1'b1;
              OP_TPLS: trig_pls <= 1'b1;
              OP_TCLR: trig_lvl <= 1'b0;
              OP_HALT: begin st <= S_DRAIN; dcnt <= 1'b0; end
              default: ;
            endcase
          end
        end
        default: begin
          fseen <= fails;
          if (abort) st <= S_IDLE;
          else if (!dcnt) dcnt <= 1'b1;
          else begin
            burst_fail <= fails;
            if (stop_now) st <= S_IDLE;
            else begin
              st <= S_RUN; csp <= '0; lsp <= '0; fseen <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (vec_valid && vec_addr == '0));
  a_r5_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_CALL) |=> (csp == $past(csp) + 1'b1));
  a_r6_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> !busy);
  a_r7_pulse_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_TPLS) |=> trig_out);
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_WAIT && !host_flag) |=> (vec_valid && $stable(vec_addr)));
  a_r9_drain_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_HALT) |=> !vec_valid);
  a_r11_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy);
endmodule

// File: tb/pat_seq_test.sv
module pat_seq_test;
  localparam int AW = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ld_en = 1'b0, start = 1'b0, abort = 1'b0, fail_in = 1'b0, host_flag = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [AW+3:0] ld_data = '0;
  logic [1:0] mode = 2'd0;
  logic [AW-1:0] vec_addr;
  logic vec_valid, busy, seq_flag, trig_out, burst_fail;
  logic [2:0] err_code;

  int n_chk = 0, n_bad = 0, act = 0, fail_at = 0;
  int exp_q[$];
  bit sb_on = 0, fail_en = 0;
  string cur_req = "";

  pat_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .abort(abort), .mode(mode), .fail_in(fail_in), .host_flag(host_flag),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .busy(busy), .seq_flag(seq_flag),
    .trig_out(trig_out), .burst_fail(burst_fail), .err_code(err_code));

  task automatic chk(string req, int a, int e);
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  always @(negedge clk) fail_in = fail_en && vec_valid && (int'(vec_addr) == fail_at);

  always @(negedge clk) if (sb_on && vec_valid) begin
    act = int'(vec_addr) * 4 + int'(trig_out) * 2 + int'(seq_flag);
    if (exp_q.size() == 0) chk({cur_req, " extra vector"}, act, -1);
    else chk(cur_req, act, exp_q.pop_front());
  end

  task automatic wr(int a, int op, int opd);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = {4'(op), AW'(opd)};
  endtask

  task automatic fini();
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2**AW; i++) wr(i, 7, 0);
  endtask

  task automatic push(int a, int t, int f);
    exp_q.push_back(a * 4 + t * 2 + f);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic burst(string req, logic [1:0] m);
    mode = m; cur_req = req; sb_on = 1;
    pulse_start();
    wait_idle();
    sb_on = 0;
    chk({req, " leftover"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 valid", vec_valid, 0); chk("R1 trig", trig_out, 0);
    chk("R1 flag", seq_flag, 0); chk("R1 err", err_code, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R9 R10: sequence and jump, until-pass stops on a clean pass
    clear_mem(); wr(0,0,0); wr(1,0,0); wr(2,1,5); wr(3,0,0); wr(4,0,0); wr(5,7,0); fini();
    push(0,0,0); push(1,0,0); push(2,0,0); push(5,0,0);
    burst("R3 jump", 2'd2);
    chk("R9 burst_fail clean", burst_fail, 0);

    // R4 nested loops
    clear_mem(); wr(0,3,2); wr(1,3,3); wr(2,0,0); wr(3,4,0); wr(4,4,0); wr(5,7,0); fini();
    push(0,0,0);
    for (int o = 0; o < 2; o++) begin
      push(1,0,0);
      for (int k = 0; k < 3; k++) begin push(2,0,0); push(3,0,0); end
      push(4,0,0);
    end
    push(5,0,0);
    burst("R4 nested loop", 2'd2);

    // R5 nested call and return
    clear_mem(); wr(0,5,10); wr(1,7,0); wr(10,5,20); wr(11,6,0); wr(20,0,0); wr(21,6,0); fini();
    push(0,0,0); push(10,0,0); push(20,0,0); push(21,0,0); push(11,0,0); push(1,0,0);
    burst("R5 call", 2'd2);
    chk("R5 no error", err_code, 0);

    // R6 errors
    clear_mem(); wr(0,5,0); fini();
    for (int k = 0; k < 9; k++) push(0,0,0);
    burst("R6 call overflow", 2'd2);
    chk("R6 call overflow code", err_code, 1);
    clear_mem(); wr(0,6,0); fini();
    push(0,0,0);
    burst("R6 return empty", 2'd2);
    chk("R6 return empty code", err_code, 2);
    clear_mem(); for (int k = 0; k < 5; k++) wr(k,3,1); fini();
    for (int k = 0; k < 5; k++) push(k,0,0);
    burst("R6 loop overflow", 2'd2);
    chk("R6 loop overflow code", err_code, 3);
    clear_mem(); wr(0,4,0); fini();
    push(0,0,0);
    burst("R6 loop end empty", 2'd2);
    chk("R6 loop end code", err_code, 4);

    // R7 trigger level and pulse; R2 start clears the error code
    clear_mem(); wr(0,10,0); wr(1,0,0); wr(2,12,0); wr(3,11,0); wr(4,0,0); wr(5,0,0); wr(6,7,0); fini();
    push(0,0,0); push(1,1,0); push(2,1,0); push(3,0,0); push(4,1,0); push(5,0,0); push(6,0,0);
    burst("R7 trigger", 2'd2);
    chk("R2 error cleared by start", err_code, 0);

    // R8 flag and host wait
    clear_mem(); wr(0,8,0); wr(1,9,0); wr(2,7,0); fini();
    mode = 2'd2; host_flag = 1'b0;
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R8 wait holds addr", int'(vec_addr), 1); chk("R8 wait valid", vec_valid, 1);
    chk("R8 flag set", seq_flag, 1);
    host_flag = 1'b1;
    @(negedge clk);
    chk("R8 wait released", int'(vec_addr), 2);
    host_flag = 1'b0;
    wait_idle();

    // R3 conditional branch taken, R10 until-fail stops, R8 flag cleared by start
    clear_mem(); wr(0,0,0); wr(1,0,0); wr(2,2,6); wr(3,7,0); wr(6,7,0); fini();
    fail_at = 2; fail_en = 1;
    push(0,0,0); push(1,0,0); push(2,0,0); push(6,0,0);
    burst("R3 branch on fail", 2'd1);
    fail_en = 0;
    chk("R10 until-fail burst_fail", burst_fail, 1);
    push(0,0,0); push(1,0,0); push(2,0,0); push(3,0,0);
    burst("R3 branch not taken", 2'd2);

    // R9 R10 R11: until-abort restarts with a two-cycle gap
    clear_mem(); wr(0,0,0); wr(1,7,0); fini();
    mode = 2'd0;
    pulse_start();
    chk("R10 first", int'(vec_addr), 0);
    @(negedge clk); chk("R9 halt vector", int'(vec_addr), 1);
    @(negedge clk); chk("R9 drain gap 1", vec_valid, 0);
    @(negedge clk); chk("R9 drain gap 2", vec_valid, 0);
    @(negedge clk); chk("R10 restart valid", vec_valid, 1); chk("R10 restart addr", int'(vec_addr), 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk("R11 abort stops", busy, 0);

    // R10 until-fail keeps restarting until a fail appears
    mode = 2'd1; fail_at = 1; fail_en = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R10 until-fail still running", busy, 1);
    fail_en = 1;
    wait_idle(); fail_en = 0;
    chk("R10 until-fail stopped", busy, 0); chk("R10 until-fail flagged", burst_fail, 1);

    // R10 until-pass keeps restarting while failing
    mode = 2'd2; fail_en = 1;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R10 until-pass still running", busy, 1);
    fail_en = 0;
    wait_idle();
    chk("R10 until-pass stopped", busy, 0); chk("R10 until-pass clean", burst_fail, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule